// File: doc/BRIEF.md
# Read-Only Counter CSR Unit

This unit serves the control-and-status register access path of a 32-bit core whose only CSRs are three free-running 64-bit counters. The counters track clock cycles, ticks of an external real-time strobe, and retired instructions. Software sees each counter as a pair of read-only 32-bit CSRs, one for the lower word and one for the upper word.

The unit takes one decoded CSR request per cycle. A request has an operation (write, set bits or clear bits), a 12-bit CSR address, a source selector (a register index or a 5-bit immediate), and a destination register index. One cycle later the unit returns the value the CSR held in the request cycle, a write-enable for the destination register, and an illegal-access flag.

Nothing can ever write these CSRs, so the read and the check of each request happen together in one step. Software that wants a full 64-bit value reads the upper word, then the lower word, then the upper word again, and retries if the two upper reads differ. The counters keep running while it does this.

Top module: `csr_counter_unit`

## Requirements
- R1: The six legal addresses are 0xC00 cycle low, 0xC01 time low, 0xC02 instret low, 0xC80 cycle high, 0xC81 time high and 0xC82 instret high. Address bit 7 selects the upper word, and bits 1:0 select the counter.
- R2: A legal request in cycle N asserts rsp_valid in cycle N+1. In that cycle rsp_data holds the selected word as it stood before the clock edge that ends cycle N.
- R3: Operation codes are 1 = write, 2 = set, 3 = clear, and 0 is reserved. A write or a reserved code is always illegal. An illegal request gives rsp_illegal=1, rsp_rd_we=0 and rsp_data=0, and it leaves every counter unchanged.
- R4: A set or clear is a legal pure read when its source is register index 0 (req_use_imm=0) or immediate 0 (req_use_imm=1). Any other set or clear is illegal.
- R5: Any address other than the six in R1 is illegal.
- R6: rsp_rd_we equals 1 only for a legal request whose req_rd is not 0. A legal request aimed at register 0 still returns the value in rsp_data.
- R7: The cycle counter increases by one on every clock edge outside reset.
- R8: The time counter increases by one on each edge where time_tick=1, and the instret counter increases by one on each edge where retire=1. Neither counter changes otherwise.
- R9: When the lower word wraps from 0xFFFFFFFF to 0, the upper word increments on that same edge. A read sequence of upper, lower, upper that spans the wrap therefore sees two different upper values.
- R10: In reset and on the first cycle after it, rsp_valid, rsp_illegal and rsp_rd_we are 0. The counters start from the parameters CYCLE_INIT, TIME_INIT and INSTRET_INIT.
- R11: rsp_valid is 0 in the cycle after a cycle with no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| time_tick | input | 1 | Real-time strobe, one count per high cycle |
| retire | input | 1 | Instruction retired strobe |
| req_valid | input | 1 | CSR request present |
| req_op | input | 2 | 1 write, 2 set, 3 clear, 0 reserved |
| req_addr | input | 12 | CSR address |
| req_use_imm | input | 1 | Source is the immediate when 1, a register when 0 |
| req_src_idx | input | 5 | Source register index |
| req_imm | input | 5 | 5-bit immediate source |
| req_rd | input | 5 | Destination register index |
| rsp_valid | output | 1 | Response present |
| rsp_illegal | output | 1 | Request was an illegal access |
| rsp_rd_we | output | 1 | Write rsp_data to the destination register |
| rsp_rd | output | 5 | Destination register index |
| rsp_data | output | 32 | CSR value before the request |

## Verification
The bench starts the time and instret counters a few counts below the lower-word wrap. It then runs the upper-lower-upper sequence across the wrap, so a design that carries into the upper word late, or never, returns matching upper reads around a lower value that has already wrapped. Set and clear are sent with zero and non-zero register and immediate sources. A unit that judges by source value rather than by index, or that faults on a pure read, fails those checks. Write, reserved-op and stray-address requests are each followed by reads, which catches a design that lets an illegal request touch a counter or write back a stale value. Back-to-back reads of the cycle counter expose an off-by-one-cycle sample point.

// File: rtl/csr_counter_unit.sv
`timescale 1ns/1ps
module csr_counter_unit #(
  parameter logic [63:0] CYCLE_INIT   = 64'd0,
  parameter logic [63:0] TIME_INIT    = 64'd0,
  parameter logic [63:0] INSTRET_INIT = 64'd0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        time_tick,
  input  logic        retire,
  input  logic        req_valid,
  input  logic [1:0]  req_op,
  input  logic [11:0] req_addr,
  input  logic        req_use_imm,
  input  logic [4:0]  req_src_idx,
  input  logic [4:0]  req_imm,
  input  logic [4:0]  req_rd,
  output logic        rsp_valid,
  output logic        rsp_illegal,
  output logic        rsp_rd_we,
  output logic [4:0]  rsp_rd,
  output logic [31:0] rsp_data
);
  localparam logic [1:0] OP_WR = 2'd1;

  logic [63:0] cyc_q, tm_q, ir_q;
  logic [63:0] sel_ctr;
  logic        addr_ok, src_zero, bad;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_q <= CYCLE_INIT;
      tm_q  <= TIME_INIT;
      ir_q  <= INSTRET_INIT;
    end else begin
      cyc_q <= cyc_q + 64'd1;
      tm_q  <= tm_q + {63'd0, time_tick};
      ir_q  <= ir_q + {63'd0, retire};
    end
  end

  assign addr_ok  = (req_addr[11:8] == 4'hC) && (req_addr[6:2] == 5'd0) && (req_addr[1:0] != 2'd3);
  assign src_zero = req_use_imm ? (req_imm == 5'd0) : (req_src_idx == 5'd0);
  assign bad      = !addr_ok || (req_op == 2'd0) || (req_op == OP_WR) || !src_zero;

  always_comb begin
    case (req_addr[1:0])
      2'd0:    sel_ctr = cyc_q;
      2'd1:    sel_ctr = tm_q;
      default: sel_ctr = ir_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid   <= 1'b0;
      rsp_illegal <= 1'b0;
      rsp_rd_we   <= 1'b0;
      rsp_rd      <= 5'd0;
      rsp_data    <= 32'd0;
    end else begin
      rsp_valid   <= req_valid;
      rsp_illegal <= req_valid && bad;
      rsp_rd_we   <= req_valid && !bad && (req_rd != 5'd0);
      rsp_rd      <= req_valid ? req_rd : 5'd0;
      if (req_valid && !bad)
        rsp_data <= req_addr[7] ? sel_ctr[63:32] : sel_ctr[31:0];
      else
        rsp_data <= 32'd0;
    end
  end
endmodule

// File: rtl/csr_counter_unit_chk.sv
`timescale 1ns/1ps
module csr_counter_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        time_tick,
  input logic        retire,
  input logic        req_valid,
  input logic        rsp_valid,
  input logic        rsp_illegal,
  input logic        rsp_rd_we,
  input logic [4:0]  rsp_rd,
  input logic [31:0] rsp_data,
  input logic [63:0] cyc_q,
  input logic [63:0] tm_q,
  input logic [63:0] ir_q
);
  assert_rsp_follows_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  assert_no_rsp_when_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  assert_illegal_no_writeback_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_illegal |-> (!rsp_rd_we && rsp_data == 32'd0));
  assert_x0_no_writeback_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_rd == 5'd0) |-> !rsp_rd_we);
  assert_cycle_steps_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (cyc_q == $past(cyc_q) + 64'd1));
  assert_time_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(time_tick)) |-> $stable(tm_q));
  assert_instret_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(retire)) |-> $stable(ir_q));
  assert_time_carry_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(time_tick) && $past(tm_q[31:0]) == 32'hFFFF_FFFF)
      |-> (tm_q[31:0] == 32'd0 && tm_q[63:32] == $past(tm_q[63:32]) + 32'd1));
endmodule

bind csr_counter_unit csr_counter_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .time_tick(time_tick), .retire(retire),
  .req_valid(req_valid), .rsp_valid(rsp_valid), .rsp_illegal(rsp_illegal),
  .rsp_rd_we(rsp_rd_we), .rsp_rd(rsp_rd), .rsp_data(rsp_data),
  .cyc_q(cyc_q), .tm_q(tm_q), .ir_q(ir_q)
);

// File: tb/tb_csr_counter_unit.sv
`timescale 1ns/1ps
module tb_csr_counter_unit;
  localparam logic [63:0] T_INIT = 64'h0000_0000_FFFF_FFFA;
  localparam logic [63:0] I_INIT = 64'h0000_0000_FFFF_FFFE;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic time_tick = 1'b0, retire = 1'b0, req_valid = 1'b0, req_use_imm = 1'b0;
  logic [1:0] req_op = 2'd0;
  logic [11:0] req_addr = 12'd0;
  logic [4:0] req_src_idx = 5'd0, req_imm = 5'd0, req_rd = 5'd0;
  logic rsp_valid, rsp_illegal, rsp_rd_we;
  logic [4:0] rsp_rd;
  logic [31:0] rsp_data;

  int checks = 0, errors = 0;
  logic [63:0] m_cyc, m_tm, m_ir;
  logic [31:0] last, hi_a, lo_a, hi_b;

  csr_counter_unit #(.CYCLE_INIT(64'd0), .TIME_INIT(T_INIT), .INSTRET_INIT(I_INIT)) dut (
    .clk(clk), .rst_n(rst_n), .time_tick(time_tick), .retire(retire),
    .req_valid(req_valid), .req_op(req_op), .req_addr(req_addr),
    .req_use_imm(req_use_imm), .req_src_idx(req_src_idx), .req_imm(req_imm),
    .req_rd(req_rd), .rsp_valid(rsp_valid), .rsp_illegal(rsp_illegal),
    .rsp_rd_we(rsp_rd_we), .rsp_rd(rsp_rd), .rsp_data(rsp_data));

  always #4 clk = ~clk;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cyc <= 64'd0; m_tm <= T_INIT; m_ir <= I_INIT;
    end else begin
      m_cyc <= m_cyc + 64'd1;
      if (time_tick) m_tm <= m_tm + 64'd1;
      if (retire)    m_ir <= m_ir + 64'd1;
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] model_word(input logic [11:0] a);
    logic [63:0] c;
    case (a[1:0])
      2'd0: c = m_cyc;
      2'd1: c = m_tm;
      default: c = m_ir;
    endcase
    return a[7] ? c[63:32] : c[31:0];
  endfunction

  // issue at a negedge, check at the following negedge (one register of latency)
  task automatic req(input string tag, input logic [1:0] op, input logic [11:0] addr,
                     input logic use_imm, input logic [4:0] idx, input logic [4:0] imm,
                     input logic [4:0] rd, input logic exp_bad);
    logic [31:0] expv;
    req_valid = 1'b1; req_op = op; req_addr = addr; req_use_imm = use_imm;
    req_src_idx = idx; req_imm = imm; req_rd = rd;
    expv = exp_bad ? 32'd0 : model_word(addr);
    @(negedge clk);
    req_valid = 1'b0;
    chk({tag, " valid"}, {63'd0, rsp_valid}, 64'd1);
    chk({tag, " illegal"}, {63'd0, rsp_illegal}, {63'd0, exp_bad});
    chk({tag, " we"}, {63'd0, rsp_rd_we}, {63'd0, !exp_bad && rd != 5'd0});
    chk({tag, " data"}, {32'd0, rsp_data}, {32'd0, expv});
    last = rsp_data;
  endtask

  task automatic rd_csr(input string tag, input logic [11:0] addr);
    req(tag, 2'd2, addr, 1'b0, 5'd0, 5'd0, 5'd7, 1'b0);
  endtask

  task automatic pulse(input bit is_tick, input int n);
    for (int i = 0; i < n; i++) begin
      if (is_tick) time_tick = 1'b1; else retire = 1'b1;
      @(negedge clk);
    end
    time_tick = 1'b0; retire = 1'b0;
  endtask

  task automatic t_reset;
    chk("R10 reset valid", {63'd0, rsp_valid}, 64'd0);
    chk("R10 reset illegal", {63'd0, rsp_illegal}, 64'd0);
    chk("R10 reset we", {63'd0, rsp_rd_we}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 first cycle valid", {63'd0, rsp_valid}, 64'd0);
    rd_csr("R10 time init low", 12'hC01);
    chk("R10 time init value", {32'd0, last}, 64'hFFFF_FFFA);
    rd_csr("R10 instret init low", 12'hC02);
    chk("R10 instret init value", {32'd0, last}, 64'hFFFF_FFFE);
  endtask

  task automatic t_rollover;
    rd_csr("R9 first high", 12'hC81);  hi_a = last;
    pulse(1'b1, 8);
    rd_csr("R9 low", 12'hC01);         lo_a = last;
    rd_csr("R9 second high", 12'hC81); hi_b = last;
    chk("R9 low wrapped", {32'd0, lo_a}, 64'd2);
    chk("R9 retry detected", {63'd0, hi_a != hi_b}, 64'd1);
    rd_csr("R9 retry high", 12'hC81);  hi_a = last;
    rd_csr("R9 retry low", 12'hC01);   lo_a = last;
    rd_csr("R9 retry high2", 12'hC81); hi_b = last;
    chk("R9 consistent", {hi_a, lo_a}, {hi_b, 32'd2});
    chk("R9 full value", {hi_a, lo_a}, 64'h1_0000_0002);
    pulse(1'b0, 2);
    rd_csr("R9 instret high", 12'hC82);
    chk("R9 instret carry", {32'd0, last}, 64'd1);
    rd_csr("R9 instret low", 12'hC02);
    chk("R9 instret low zero", {32'd0, last}, 64'd0);
  endtask

  task automatic t_map_and_cycle;
    logic [31:0] a;
    rd_csr("R1 cycle low", 12'hC00);   a = last;
    rd_csr("R7 cycle low again", 12'hC00);
    chk("R7 back-to-back step", {32'd0, last - a}, 64'd1);
    rd_csr("R1 cycle high", 12'hC80);
    rd_csr("R1 time high", 12'hC81);
    rd_csr("R1 instret high", 12'hC82);
  endtask

  task automatic t_strobes;
    logic [31:0] t0;
    rd_csr("R8 time before", 12'hC01); t0 = last;
    pulse(1'b0, 5);
    rd_csr("R8 time after retires", 12'hC01);
    chk("R8 time held", {32'd0, last}, {32'd0, t0});
    rd_csr("R8 instret after retires", 12'hC02);
    chk("R8 instret count", {32'd0, last}, 64'd5);
    pulse(1'b1, 3);
    rd_csr("R8 time after ticks", 12'hC01);
    chk("R8 time count", {32'd0, last}, {32'd0, t0 + 32'd3});
  endtask

  task automatic t_illegal;
    req("R3 write x0", 2'd1, 12'hC02, 1'b0, 5'd0, 5'd0, 5'd4, 1'b1);
    req("R3 write reg", 2'd1, 12'hC82, 1'b0, 5'd9, 5'd0, 5'd4, 1'b1);
    req("R3 reserved op", 2'd0, 12'hC00, 1'b0, 5'd0, 5'd0, 5'd4, 1'b1);
    rd_csr("R3 instret untouched", 12'hC02);
    chk("R3 instret value", {32'd0, last}, 64'd5);
    req("R4 set reg", 2'd2, 12'hC01, 1'b0, 5'd3, 5'd0, 5'd4, 1'b1);
    req("R4 clear imm", 2'd3, 12'hC01, 1'b1, 5'd0, 5'd7, 5'd4, 1'b1);
    req("R4 set imm zero", 2'd2, 12'hC01, 1'b1, 5'd3, 5'd0, 5'd4, 1'b0);
    req("R4 clear x0", 2'd3, 12'hC81, 1'b0, 5'd0, 5'd19, 5'd4, 1'b0);
    req("R5 addr C03", 2'd2, 12'hC03, 1'b0, 5'd0, 5'd0, 5'd4, 1'b1);
    req("R5 addr C83", 2'd2, 12'hC83, 1'b0, 5'd0, 5'd0, 5'd4, 1'b1);
    req("R5 addr 300", 2'd2, 12'h300, 1'b0, 5'd0, 5'd0, 5'd4, 1'b1);
    req("R5 addr C40", 2'd2, 12'hC40, 1'b0, 5'd0, 5'd0, 5'd4, 1'b1);
    req("R6 rd zero", 2'd2, 12'hC02, 1'b0, 5'd0, 5'd0, 5'd0, 1'b0);
  endtask

  task automatic t_idle;
    @(negedge clk);
    @(negedge clk);
    chk("R11 idle no response", {63'd0, rsp_valid}, 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_rollover();
    t_map_and_cycle();
    t_strobes();
    t_illegal();
    t_idle();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule